// File: doc/BRIEF.md
# Pre-Trigger Capture Buffer Controller

This block records probe samples into a circular memory of fixed depth so that each acquisition holds a programmable number of samples taken before a trigger, together with the samples taken from the trigger onward. An arm request latches the trigger position, which is the number of pre-trigger samples to keep. The block then waits for a trigger pulse from an external match unit and keeps writing until the post-trigger quota is full. After that it raises a done flag and stops writing.

A storage qualifier can be switched on so that only cycles whose qualifier input is high are written. The trigger cycle is always written. The memory address of the trigger sample is reported, along with the number of valid pre-trigger samples. A trigger can arrive before the pre-trigger quota has filled, and this count shows how many samples from before the trigger are actually in the record. The readout port takes an index relative to the oldest stored sample and returns the record in time order.

The depth must be a power of two. The trigger position ranges from 0 to DEPTH-1. A record holds `preValid + (DEPTH - position)` samples.

Top module: `capture_buf`

## Requirements
- R1: After reset, `done` and `busy` are 0. A trigger pulse in this idle state is ignored, and `busy` stays 0.
- R2: A one-cycle `armReq` in any state restarts the acquisition. In the next cycle `busy` is 1 and `done` is 0. No sample is written in the arm cycle.
- R3: A cycle is qualified when `qualEn` is 0 or `qualIn` is 1. While the block is armed or counting post-trigger samples, only qualified cycles are written. The trigger cycle is the one exception.
- R4: The trigger cycle is always written. `trigAddr` gives the memory address of the trigger sample, which is the number of writes since arm, modulo DEPTH.
- R5: Exactly DEPTH minus the position samples are stored from the trigger onward, counting the trigger sample, and only qualified cycles count toward this. `done` rises in the cycle after the last of these writes. While `done` is 1, nothing is written.
- R6: When the trigger comes after at least position qualified samples, the record keeps the position most recent samples before the trigger, and `preValid` equals the position.
- R7: When the trigger comes early, the record keeps every sample stored before it, and `preValid` equals that count, which is less than the position.
- R8: `rdData` shows the record entry selected by `rdIdx`, with index 0 the oldest sample and indices rising in time order. Index `preValid` is the trigger sample.
- R9: With position 0, the trigger sample is record index 0 and `preValid` is 0.
- R10: A trigger pulse while counting post-trigger samples, or after done, changes neither `trigAddr` nor the stored record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armReq | input | 1 | Start a new acquisition, with priority over all else |
| trigPos | input | ADDR_W | Pre-trigger sample count, latched on arm |
| trigIn | input | 1 | Trigger pulse from the match unit |
| qualEn | input | 1 | Enable the storage qualifier |
| qualIn | input | 1 | Qualifier condition |
| probeData | input | DATA_W | Sample to record |
| busy | output | 1 | Acquisition in progress |
| done | output | 1 | Record complete |
| trigAddr | output | ADDR_W | Memory address of the trigger sample |
| preValid | output | ADDR_W | Valid pre-trigger samples in the record |
| rdIdx | input | ADDR_W | Readout index, with 0 the oldest sample |
| rdData | output | DATA_W | Sample at the readout index |

## Verification
The bench goes after the following corner cases. An early trigger: a design that assumes a full pre-trigger window would read the oldest entry from stale memory and report the wrong `preValid`. A trigger on an unqualified cycle: a design that gates it with the qualifier would lose the reference sample. Position 0 and position DEPTH-1: the first needs no pre-trigger phase, and the second completes on the trigger itself, so an off-by-one in the post-trigger count shows up as a missing or extra sample. Extra trigger pulses after triggering, and a re-arm in the middle of post-trigger counting, expose a design that moves the trigger mark again or fails to restart cleanly.

// File: rtl/capture_buf_pkg.sv
package capture_buf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_POST,
    ST_DONE
  } capState_t;

  typedef struct packed {
    logic clr;       // restart: pointer and trigger mark to zero
    logic wrEn;      // write probe sample at the write pointer
    logic markTrig;  // the current write is the trigger sample
  } capStrobe_t;

endpackage

// File: rtl/capture_buf_ctrl.sv
module capture_buf_ctrl
  import capture_buf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic [ADDR_W-1:0] trigPos,
  input  logic              trigIn,
  input  logic              qualEn,
  input  logic              qualIn,
  output capStrobe_t        stb,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] preValid
);

  localparam logic [ADDR_W:0] DEPTH_V = ADDR_W'(DEPTH - 1) + 1'b1;

  capState_t         state;
  logic [ADDR_W-1:0] posReg;
  logic [ADDR_W-1:0] preCnt;
  logic [ADDR_W:0]   postLeft;
  logic              qual;
  logic              armed;

  assign qual  = !qualEn || qualIn;
  assign armed = (state == ST_FILL) || (state == ST_WAIT);
  assign busy  = armed || (state == ST_POST);
  assign done  = (state == ST_DONE);
  assign preValid = preCnt;

  always_comb begin
    stb.clr      = armReq;
    stb.markTrig = !armReq && armed && trigIn;
    stb.wrEn     = !armReq && ((armed && (trigIn || qual)) ||
                               ((state == ST_POST) && qual));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      posReg   <= '0;
      preCnt   <= '0;
      postLeft <= '0;
    end else if (armReq) begin
      posReg <= trigPos;
      preCnt <= '0;
      state  <= (trigPos == '0) ? ST_WAIT : ST_FILL;
    end else begin
      unique case (state)
        ST_FILL, ST_WAIT: begin
          if (trigIn) begin
            postLeft <= DEPTH_V - {1'b0, posReg} - 1'b1;
            state    <= (posReg == ADDR_W'(DEPTH - 1)) ? ST_DONE : ST_POST;
          end else if (qual && state == ST_FILL) begin
            preCnt <= preCnt + 1'b1;
            if (ADDR_W'(preCnt + 1'b1) == posReg) state <= ST_WAIT;
          end
        end
        ST_POST: begin
          if (qual) begin
            postLeft <= postLeft - 1'b1;
            if (postLeft == 1) state <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (busy && !done));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !armReq) |=> done);

  a_r7_pre_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (preCnt <= posReg));

  a_r1_idle_trig_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !armReq) |=> !busy);

endmodule

// File: rtl/capture_buf_dp.sv
module capture_buf_dp
  import capture_buf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        stb,
  input  logic              done,
  input  logic [DATA_W-1:0] probeData,
  input  logic [ADDR_W-1:0] preValid,
  input  logic [ADDR_W-1:0] rdIdx,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      trigAddr <= '0;
    end else if (stb.clr) begin
      wrPtr    <= '0;
      trigAddr <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (stb.markTrig) trigAddr <= wrPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr] <= probeData;
  end

  // oldest sample sits preValid entries before the trigger
  assign rdAddr = trigAddr - preValid + rdIdx;
  assign rdData = mem[rdAddr];

  a_r5_no_write_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stb.wrEn);

  a_r4_trig_is_written: assert property (@(posedge clk) disable iff (!rstN)
    stb.markTrig |-> stb.wrEn);

  a_r10_mark_held: assert property (@(posedge clk) disable iff (!rstN)
    (done && !stb.clr) |=> $stable(trigAddr));

endmodule

// File: rtl/capture_buf.sv
module capture_buf
  import capture_buf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic [ADDR_W-1:0] trigPos,
  input  logic              trigIn,
  input  logic              qualEn,
  input  logic              qualIn,
  input  logic [DATA_W-1:0] probeData,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [ADDR_W-1:0] preValid,
  input  logic [ADDR_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData
);

  capStrobe_t stb;

  capture_buf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .armReq(armReq), .trigPos(trigPos),
    .trigIn(trigIn), .qualEn(qualEn), .qualIn(qualIn), .stb(stb),
    .busy(busy), .done(done), .preValid(preValid)
  );

  capture_buf_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .done(done), .probeData(probeData),
    .preValid(preValid), .rdIdx(rdIdx), .trigAddr(trigAddr), .rdData(rdData)
  );

endmodule

// File: tb/capture_buf_tb.sv
`timescale 1ns/1ps
module capture_buf_tb;
  localparam int DEPTH = 16;
  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 0, rstN = 0, armReq = 0, trigIn = 0, qualEn = 0, qualIn = 0;
  logic [AW-1:0] trigPos = '0, rdIdx = '0;
  logic [DW-1:0] probeData = '0;
  logic busy, done;
  logic [AW-1:0] trigAddr, preValid;
  logic [DW-1:0] rdData;

  int total = 0, bad = 0;

  // reference model state: 0 idle,1 fill,2 wait,3 post,4 done
  int mState = 0, mPos = 0, mWrites = 0, mTrigAddr = 0, mPre = 0, mPost = 0;
  logic [DW-1:0] q[$];

  always #5 clk = ~clk;

  capture_buf #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .armReq(armReq), .trigPos(trigPos),
    .trigIn(trigIn), .qualEn(qualEn), .qualIn(qualIn), .probeData(probeData),
    .busy(busy), .done(done), .trigAddr(trigAddr), .preValid(preValid),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; q.delete(); mWrites = 0;
    end else if (armReq) begin
      mPos = trigPos; q.delete(); mWrites = 0;
      mState = (mPos == 0) ? 2 : 1;
    end else if (mState == 1 || mState == 2) begin
      if (trigIn) begin
        q.push_back(probeData);
        mTrigAddr = mWrites % DEPTH; mPre = q.size() - 1; mWrites++;
        mPost = DEPTH - mPos - 1;
        mState = (mPost == 0) ? 4 : 3;
      end else if (!qualEn || qualIn) begin
        q.push_back(probeData); mWrites++;
        if (mState == 1 && q.size() == mPos) mState = 2;
        else if (mState == 2 && q.size() > mPos) void'(q.pop_front());
      end
    end else if (mState == 3) begin
      if (!qualEn || qualIn) begin
        q.push_back(probeData); mWrites++; mPost--;
        if (mPost == 0) mState = 4;
      end
    end
  end

  // per-cycle comparison of control outputs (R1 R2 R5)
  always @(negedge clk) if (rstN) begin
    chk("R5 done", int'(done), int'(mState == 4));
    chk("R2 busy", int'(busy), int'(mState >= 1 && mState <= 3));
  end

  task automatic cyc(logic arm, logic trg, logic ql, logic [DW-1:0] d);
    @(negedge clk); #1;
    armReq = arm; trigIn = trg; qualIn = ql; probeData = d;
  endtask

  task automatic checkRecord(string req);
    cyc(0, 0, 0, 8'hEE);
    chk({req, " preValid"}, int'(preValid), mPre);
    chk({req, " R4 trigAddr"}, int'(trigAddr), mTrigAddr);
    for (int i = 0; i < q.size(); i++) begin
      rdIdx = AW'(i); #1;
      chk({req, " R8 rdData"}, int'(rdData), int'(q[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1; chk("R1 reset done", int'(done), 0); chk("R1 reset busy", int'(busy), 0);
    #20 rstN = 1;
    // R1: trigger in idle ignored
    cyc(0, 1, 0, 8'h01); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R1 idle trig", int'(busy), 0);

    // R6: full pre-trigger window, no qualifier, wraps memory
    qualEn = 0; trigPos = 5;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, DW'(8'h10 + i));
    cyc(0, 1, 0, 8'hA5);
    for (int i = 0; i < 15; i++) cyc(0, 0, 0, DW'(8'h40 + i));
    chk("R5 done after quota", int'(done), 1);
    chk("R6 preValid full", mPre, 5);
    checkRecord("R6");

    // R10: trigger after done changes nothing
    cyc(0, 1, 1, 8'h77); cyc(0, 0, 0, 8'h78);
    checkRecord("R10 after done");

    // R3 R7: qualifier on, early trigger on an unqualified cycle
    qualEn = 1; trigPos = 6;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0], DW'(8'h20 + i));
    cyc(0, 1, 0, 8'hC3);
    for (int i = 0; i < 24; i++) cyc(0, 0, i[0] | i[2], DW'(8'h60 + i));
    chk("R7 early preValid", mPre, 3);
    chk("R3 done", int'(done), 1);
    checkRecord("R3 R7");

    // R9: position 0, R10 extra triggers during post, then re-arm mid-post (R2)
    qualEn = 0; trigPos = 0;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 8'h90); cyc(0, 1, 0, 8'h91);
    cyc(0, 1, 0, 8'h92); cyc(0, 0, 0, 8'h93); cyc(0, 1, 0, 8'h94);
    trigPos = 2;
    cyc(1, 0, 0, 8'h95);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, DW'(8'hB0 + i));
    cyc(0, 1, 0, 8'hBF);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, DW'(8'hD0 + i));
    chk("R2 rearm pre", mPre, 2);
    checkRecord("R2 R10");
    trigPos = 0;
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 8'h5A);
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, DW'(i));
    chk("R9 preValid zero", int'(preValid), 0);
    checkRecord("R9");

    // R5: last position completes on the trigger itself
    trigPos = AW'(DEPTH - 1);
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, DW'(8'h30 + i));
    cyc(0, 1, 0, 8'hF0);
    cyc(0, 0, 0, 8'hF1);
    chk("R5 done on trigger", int'(done), 1);
    checkRecord("R5 max pos");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule